// File: doc/BRIEF.md
# Reference clock switch sequencer

This block moves a PLL onto a different reference clock by issuing a short, fixed series of accesses on a memory-mapped reconfiguration port. A request carries a 3-bit logical clock index. The PLL has two reference clock selection multiplexers. For each one, the block reads a per-logical-clock lookup register to get a 5-bit physical clock code. It then reads the multiplexer's select register and writes it back with the low five bits replaced by that code. Multiplexer 0 is handled completely before multiplexer 1 is started.

The block acts as a bus master on an 8-bit data, 10-bit address port. The port has a wait-request handshake. The block does not touch the port until a grant input shows that the port has been handed over. After the last write, it pulses a recalibrate/release request and waits for a done input. Only then does it report completion. Busy, done and error outputs report the outcome of each request. Every single access is guarded by a timeout, so a stuck port cannot hang the sequence.

Top module: `refclk_switch_seq`

## Requirements
- R1: Logical indices 0 to 4 are accepted when idle. An index of 5, 6 or 7 raises `error` for exactly one cycle, in the cycle after the request. `busy` stays low and no bus access is made.
- R2: Addresses used: the multiplexer 0 select register is at 0x114, and its lookup registers are at 0x117 + index. The multiplexer 1 select register is at 0x11C, and its lookup registers are at 0x11D + index.
- R3: An accepted request makes exactly six accesses, in this order: lookup read, select read and select write for multiplexer 0, then the same three for multiplexer 1.
- R4: Each select write carries bits [7:5] of the value just read from that select register, and bits [4:0] of the value read from the lookup register. Bits [7:5] of the lookup value have no effect.
- R5: While a request waits for `grant`, `bus_read` and `bus_write` stay low.
- R6: While `bus_waitreq` is high, an access holds `bus_addr`, `bus_read`, `bus_write` and `bus_wdata` unchanged. Read data is taken in the cycle in which `bus_waitreq` is low. Read and write are never both high.
- R7: After the final write completes, `recal_req` is high for exactly one cycle. `done` goes high for one cycle, in the cycle after `recal_done` is sampled high. `busy` is high from the cycle after acceptance until `done` rises, and it is low when `done` is high.
- R8: A request presented while `busy` is high is ignored. It causes no error and does not change the index in use.
- R9: If `bus_waitreq` stays high for 1024 cycles of a single access, the access is dropped. `error` pulses for one cycle and `busy` falls, with no further access.
- R10: During and after reset, `busy`, `done`, `error`, `recal_req`, `bus_read` and `bus_write` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Switch request strobe |
| req_idx | input | 3 | Logical reference clock index |
| grant | input | 1 | Reconfiguration port handed to this block |
| recal_done | input | 1 | Release/recalibration finished |
| bus_waitreq | input | 1 | Port stall; access completes when low |
| bus_rdata | input | 8 | Read data |
| bus_addr | output | 10 | Access address |
| bus_read | output | 1 | Read access active |
| bus_write | output | 1 | Write access active |
| bus_wdata | output | 8 | Write data |
| recal_req | output | 1 | One-cycle release/recalibrate request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle pulse for a bad index or a timeout |

## Verification
Two events can land in the same cycle: the sequence finishing on `recal_done`, and a new request arriving. The bench provokes this by presenting a request with an out-of-range index in the exact cycle it drives `recal_done`. One cycle later, `done` must be high while `error` stays low, because the request was seen while the block was still busy. A second overlap occurs during the grant wait. There, a valid request with a different index is injected, and the scoreboard confirms that the six accesses that follow still target the original index.

// File: rtl/refclk_switch_pkg.sv
package refclk_switch_pkg;

  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned CODE_W = 5;
  localparam int unsigned NUM_REFCLK = 5;

  localparam logic [ADDR_W-1:0] MUX0_SEL_ADDR = 10'h114;
  localparam logic [ADDR_W-1:0] MUX0_LUT_BASE = 10'h117;
  localparam logic [ADDR_W-1:0] MUX1_SEL_ADDR = 10'h11C;
  localparam logic [ADDR_W-1:0] MUX1_LUT_BASE = 10'h11D;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRANT,
    ST_LUT_RD,
    ST_SEL_RD,
    ST_SEL_WR,
    ST_RECAL,
    ST_WAIT_DONE
  } seq_state_e;

  function automatic logic idx_ok(input logic [IDX_W-1:0] idx);
    return ({29'd0, idx} < NUM_REFCLK);
  endfunction

  function automatic logic [ADDR_W-1:0] lut_addr(input logic mux, input logic [IDX_W-1:0] idx);
    logic [ADDR_W-1:0] base;
    base = mux ? MUX1_LUT_BASE : MUX0_LUT_BASE;
    return base + {{(ADDR_W-IDX_W){1'b0}}, idx};
  endfunction

  function automatic logic [ADDR_W-1:0] sel_addr(input logic mux);
    return mux ? MUX1_SEL_ADDR : MUX0_SEL_ADDR;
  endfunction

  function automatic logic [DATA_W-1:0] merge_code(input logic [DATA_W-1:0] old_sel,
                                                   input logic [CODE_W-1:0] code);
    return {old_sel[DATA_W-1:CODE_W], code};
  endfunction

endpackage

// File: rtl/refclk_bus_port.sv
module refclk_bus_port #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TIMEOUT_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              bus_waitreq,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_read,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              ack,
  output logic              tmo
);

  localparam int unsigned CNT_W = (TIMEOUT_CYCLES < 2) ? 1 : $clog2(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic             active;
  logic [CNT_W-1:0] stall_cnt;
  logic             at_limit;

  assign active   = bus_read | bus_write;
  assign at_limit = (stall_cnt == CNT_LAST);
  assign ack      = active & ~bus_waitreq;
  assign tmo      = active & bus_waitreq & at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_read  <= 1'b0;
      bus_write <= 1'b0;
      bus_wdata <= '0;
      stall_cnt <= '0;
    end else if (!active) begin
      if (start) begin
        bus_addr  <= start_addr;
        bus_read  <= ~start_wr;
        bus_write <= start_wr;
        bus_wdata <= start_wdata;
        stall_cnt <= '0;
      end
    end else if (ack || tmo) begin
      bus_read  <= 1'b0;
      bus_write <= 1'b0;
      stall_cnt <= '0;
    end else begin
      stall_cnt <= stall_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/refclk_seq_ctrl.sv
module refclk_seq_ctrl
  import refclk_switch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              grant,
  input  logic              recal_done,
  input  logic              ack,
  input  logic              tmo,
  input  logic [DATA_W-1:0] rdata,
  output logic              start,
  output logic              start_wr,
  output logic [ADDR_W-1:0] start_addr,
  output logic [DATA_W-1:0] start_wdata,
  output logic              recal_req,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              wait_grant
);

  seq_state_e        state;
  logic [IDX_W-1:0]  idx_q;
  logic              mux_q;
  logic [CODE_W-1:0] code_q;
  logic [DATA_W-1:0] sel_q;
  logic              issued;
  logic              in_access;

  assign in_access   = (state == ST_LUT_RD) || (state == ST_SEL_RD) || (state == ST_SEL_WR);
  assign start       = in_access & ~issued;
  assign start_wr    = (state == ST_SEL_WR);
  assign start_addr  = (state == ST_LUT_RD) ? lut_addr(mux_q, idx_q) : sel_addr(mux_q);
  assign start_wdata = merge_code(sel_q, code_q);
  assign recal_req   = (state == ST_RECAL);
  assign busy        = (state != ST_IDLE);
  assign wait_grant  = (state == ST_GRANT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx_q  <= '0;
      mux_q  <= 1'b0;
      code_q <= '0;
      sel_q  <= '0;
      issued <= 1'b0;
      done   <= 1'b0;
      error  <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (idx_ok(req_idx)) begin
              idx_q <= req_idx;
              mux_q <= 1'b0;
              state <= ST_GRANT;
            end else begin
              error <= 1'b1;
            end
          end
        end
        ST_GRANT: begin
          if (grant) begin
            issued <= 1'b0;
            state  <= ST_LUT_RD;
          end
        end
        ST_LUT_RD, ST_SEL_RD, ST_SEL_WR: begin
          if (start) begin
            issued <= 1'b1;
          end else if (tmo) begin
            issued <= 1'b0;
            error  <= 1'b1;
            state  <= ST_IDLE;
          end else if (ack) begin
            issued <= 1'b0;
            if (state == ST_LUT_RD) begin
              code_q <= rdata[CODE_W-1:0];
              state  <= ST_SEL_RD;
            end else if (state == ST_SEL_RD) begin
              sel_q <= rdata;
              state <= ST_SEL_WR;
            end else if (!mux_q) begin
              mux_q <= 1'b1;
              state <= ST_LUT_RD;
            end else begin
              state <= ST_RECAL;
            end
          end
        end
        ST_RECAL: state <= ST_WAIT_DONE;
        ST_WAIT_DONE: begin
          if (recal_done) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/refclk_switch_seq.sv
module refclk_switch_seq
  import refclk_switch_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              grant,
  input  logic              recal_done,
  input  logic              bus_waitreq,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_read,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              recal_req,
  output logic              busy,
  output logic              done,
  output logic              error
);

  logic              acc_start;
  logic              acc_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic              acc_ack;
  logic              tmo_evt;
  logic              wait_grant;

  refclk_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_idx     (req_idx),
    .grant       (grant),
    .recal_done  (recal_done),
    .ack         (acc_ack),
    .tmo         (tmo_evt),
    .rdata       (bus_rdata),
    .start       (acc_start),
    .start_wr    (acc_wr),
    .start_addr  (acc_addr),
    .start_wdata (acc_wdata),
    .recal_req   (recal_req),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .wait_grant  (wait_grant)
  );

  refclk_bus_port #(
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (acc_start),
    .start_wr    (acc_wr),
    .start_addr  (acc_addr),
    .start_wdata (acc_wdata),
    .bus_waitreq (bus_waitreq),
    .bus_addr    (bus_addr),
    .bus_read    (bus_read),
    .bus_write   (bus_write),
    .bus_wdata   (bus_wdata),
    .ack         (acc_ack),
    .tmo         (tmo_evt)
  );

endmodule

// File: rtl/refclk_switch_seq_chk.sv
module refclk_switch_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_idx,
  input logic       recal_done,
  input logic       bus_waitreq,
  input logic [9:0] bus_addr,
  input logic       bus_read,
  input logic       bus_write,
  input logic [7:0] bus_wdata,
  input logic       recal_req,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic       wait_grant,
  input logic       tmo_evt
);

  p_bad_idx_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_idx > 3'd4) |=> (error && !busy));

  p_write_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write |-> (bus_addr == 10'h114 || bus_addr == 10'h11C));

  p_no_access_before_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_grant |-> (!bus_read && !bus_write));

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_read || bus_write) && bus_waitreq && !tmo_evt) |=>
      ($stable(bus_addr) && $stable(bus_read) && $stable(bus_write) && $stable(bus_wdata)));

  p_one_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_read && bus_write));

  p_recal_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |=> (!recal_req && busy));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_recal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(recal_done) && !busy));

  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && !tmo_evt) |=> !error);

  p_timeout_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (error && !busy && !bus_read && !bus_write));

endmodule

bind refclk_switch_seq refclk_switch_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_idx     (req_idx),
  .recal_done  (recal_done),
  .bus_waitreq (bus_waitreq),
  .bus_addr    (bus_addr),
  .bus_read    (bus_read),
  .bus_write   (bus_write),
  .bus_wdata   (bus_wdata),
  .recal_req   (recal_req),
  .busy        (busy),
  .done        (done),
  .error       (error),
  .wait_grant  (wait_grant),
  .tmo_evt     (tmo_evt)
);

// File: tb/test_refclk_switch_seq.sv
`timescale 1ns/1ps
module test_refclk_switch_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_idx = '0;
  logic       grant = 1'b0;
  logic       recal_done = 1'b0;
  logic       bus_waitreq = 1'b1;
  logic [7:0] bus_rdata = '0;
  logic [9:0] bus_addr;
  logic       bus_read, bus_write;
  logic [7:0] bus_wdata;
  logic       recal_req, busy, done, error;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  int act_cycles = 0;
  int wait_cfg = 0;
  int wcnt = 0;
  bit stall = 1'b0;
  bit finished = 1'b0;

  logic [7:0]  mem [0:1023];
  logic [18:0] exp_q [$];

  always #2 clk = ~clk;

  refclk_switch_seq i_refclk_switch_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .grant(grant), .recal_done(recal_done), .bus_waitreq(bus_waitreq),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_read(bus_read),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .recal_req(recal_req),
    .busy(busy), .done(done), .error(error)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // Responder and scoreboard monitor: decides the wait-request seen at the next edge
  always @(negedge clk) begin
    if (bus_read || bus_write) begin
      act_cycles++;
      if (stall || wcnt < wait_cfg) begin
        bus_waitreq = 1'b1;
        if (!stall) wcnt++;
      end else begin
        logic [18:0] got;
        bus_waitreq = 1'b0;
        wcnt = 0;
        if (bus_read) begin
          bus_rdata = mem[bus_addr];
          got = {1'b0, bus_addr, 8'h00};
        end else begin
          mem[bus_addr] = bus_wdata;
          got = {1'b1, bus_addr, bus_wdata};
        end
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected access", int'(got), 0);
        end else begin
          logic [18:0] want;
          want = exp_q.pop_front();
          check(got == want, "R2 R3 R4 R6 access kind/address/data", int'(got), int'(want));
        end
      end
    end else begin
      bus_waitreq = 1'b1;
      wcnt = 0;
    end
  end

  task automatic push_mux(input logic [9:0] lut, input logic [9:0] sel);
    logic [7:0] code, old, nw;
    code = mem[lut];
    old  = mem[sel];
    nw   = (old & 8'hE0) | (code & 8'h1F);
    exp_q.push_back({1'b0, lut, 8'h00});
    exp_q.push_back({1'b0, sel, 8'h00});
    exp_q.push_back({1'b1, sel, nw});
  endtask

  task automatic switch_once(input int idx, input int wcfg, input int gdel, input int ddel);
    int n;
    wait_cfg = wcfg;
    push_mux(10'(10'h117 + idx), 10'h114);
    push_mux(10'(10'h11D + idx), 10'h11C);
    @(negedge clk); req_valid = 1'b1; req_idx = 3'(idx);
    @(negedge clk);
    check(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    // R8: a competing valid request during the grant wait must be ignored
    req_idx = 3'((idx + 1) % 5);
    for (int i = 0; i < gdel; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      check(!bus_read && !bus_write, "R5 no access before grant",
            int'({bus_read, bus_write}), 0);
    end
    req_valid = 1'b0;
    grant = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!recal_req && n < 5000);
    check(recal_req == 1'b1, "R7 recal request after last write", int'(recal_req), 1);
    check(exp_q.size() == 0, "R3 six accesses before recal", exp_q.size(), 0);
    grant = 1'b0;
    @(negedge clk);
    check(recal_req == 1'b0, "R7 recal request one cycle", int'(recal_req), 0);
    for (int i = 0; i < ddel; i++) begin
      check(done == 1'b0 && busy == 1'b1, "R7 wait for recal_done",
            int'({done, busy}), 1);
      @(negedge clk);
    end
    // R8: out-of-range request in the very cycle recal_done is sampled
    recal_done = 1'b1; req_valid = 1'b1; req_idx = 3'd7;
    @(negedge clk);
    recal_done = 1'b0; req_valid = 1'b0;
    check(done && !busy && !error, "R7 R8 done and no error on overlap",
          int'({done, busy, error}), 4);
    @(negedge clk);
    check(!done && !error, "R7 done one cycle", int'({done, error}), 0);
  endtask

  task automatic bad_req(input int idx);
    int n0;
    n0 = act_cycles;
    @(negedge clk); req_valid = 1'b1; req_idx = 3'(idx);
    @(negedge clk); req_valid = 1'b0;
    check(error && !busy, "R1 bad index error", int'({error, busy}), 2);
    @(negedge clk);
    check(!error && !busy, "R1 error one cycle", int'({error, busy}), 0);
    check(act_cycles == n0, "R1 no bus traffic", act_cycles - n0, 0);
  endtask

  initial begin
    for (int a = 0; a < 1024; a++) mem[a] = 8'((a * 37 + 11) ^ (a >> 3));
    mem[10'h114] = 8'hA3;
    mem[10'h11C] = 8'h47;
    for (int i = 0; i < 5; i++) begin
      mem[10'(10'h117 + i)] = 8'(8'hE0 | (i * 3 + 1));
      mem[10'(10'h11D + i)] = 8'(8'hA0 | (i * 5 + 2));
    end

    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !recal_req && !bus_read && !bus_write,
          "R10 reset state", int'({busy, done, error, recal_req, bus_read, bus_write}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !error && !recal_req && !bus_read && !bus_write,
          "R10 after reset", int'({busy, done, error, recal_req, bus_read, bus_write}), 0);

    switch_once(0, 0, 1, 0);
    switch_once(4, 3, 4, 2);
    bad_req(5);
    bad_req(7);
    switch_once(3, 1, 2, 5);

    // R9: stuck port on the first access
    begin
      int n_act;
      int n;
      logic [7:0] sel_before;
      sel_before = mem[10'h114];
      stall = 1'b1;
      n_act = 0; n = 0;
      @(negedge clk); req_valid = 1'b1; req_idx = 3'd2;
      @(negedge clk); req_valid = 1'b0; grant = 1'b1;
      while (!error && n < 3000) begin
        @(negedge clk);
        n++;
        if (bus_read || bus_write) n_act++;
      end
      check(error == 1'b1, "R9 timeout error", int'(error), 1);
      check(n_act == 1024, "R9 stall cycles before abort", n_act, 1024);
      check(!busy && !bus_read && !bus_write, "R9 idle after abort",
            int'({busy, bus_read, bus_write}), 0);
      grant = 1'b0; stall = 1'b0;
      @(negedge clk);
      check(!error && !bus_read, "R9 error one cycle, no retry", int'({error, bus_read}), 0);
      check(mem[10'h114] == sel_before, "R9 select untouched", int'(mem[10'h114]), int'(sel_before));
    end

    switch_once(2, 2, 1, 1);
    switch_once(1, 0, 3, 0);
    bad_req(6);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule